// File: doc/BRIEF.md
# Clock Generator Strap Capture and Decode

This block is the configuration front end of a multi-output clock generator. A handful of shared pads do two jobs: while power-on reset is held they carry strap levels that pick the chip's operating options, and once reset is released they become clock outputs. The block samples every strap on each clock edge while reset is active, so the value seen on the last reset cycle is the one kept. On the first edge after release it freezes that value, decodes it and registers the result. After a parameterised delay it turns on the pad output drivers.

Each strap arrives as a 2-bit level code already resolved by the pad: low, high or mid. Mid means the pad was left open. Three straps are two-level and two are three-level. The decoded results are a spread-spectrum depth code for the 27 MHz output, a crystal-frequency select, a supply-routing select and a mode for the 8/10 MHz output. These values stay frozen until the next power-on reset.

Top module: `clkgen_strap_frontend`

## Requirements
- R1: While reset is held (synchronous, active-low `rst_n`), all pad output enables are 0, the spread code is 0, `xtal_alt_o` and `supply_alt_o` are 0 and `mode_o` is 01 (8 MHz).
- R2: Level codes are 00 = low, 01 = high, 10 = mid. The spread code is (3 if the upper spread strap is high, else 0) plus (0 if the lower strap is mid, 1 if low, 2 if high). This gives 0 = off, 1 = ±0.5%, 2 = ±0.75%, 3 = ±1%, 4 = ±1.25% and 5 = ±1.5%.
- R3: `xtal_alt_o` is 1 only when the crystal strap is high (14.31818 MHz crystal, pass-through on the 27 MHz pin). Any other code gives 0 (24.576 MHz crystal).
- R4: `supply_alt_o` is 1 only when the supply strap is high (second 24.576 MHz and 12 MHz outputs move to the Ethernet-clock supply). Any other code gives 0.
- R5: `mode_o` is 01 (8 MHz, Ethernet-clock supply) for mid, 10 (10 MHz, group B2 supply) for high and 00 (output off) for low.
- R6: Code 11 on a three-level strap (lower spread, 8/10 MHz mode) decodes as mid. Code 11 or 10 on a two-level strap (upper spread, crystal, supply) decodes as low.
- R7: The decoded outputs reflect the strap codes present on the last clock edge with reset held, and they update on the first edge with reset released.
- R8: After that first edge, strap pin changes have no effect on any output until reset is asserted again.
- R9: The pad enables rise exactly OE_DELAY edges after the capture edge. Pads 0 to 3 are enabled, and pad 4 (8/10 MHz) is enabled only when `mode_o` is not 00.
- R10: Asserting reset again after operation clears all enables and restores the R1 values. The next release captures fresh strap values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, running during reset |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| strap_spr_hi_i | input | 2 | Level code, upper spread strap (two-level) |
| strap_spr_lo_i | input | 2 | Level code, lower spread strap (three-level) |
| strap_xtal_i | input | 2 | Level code, crystal select strap (two-level) |
| strap_supply_i | input | 2 | Level code, supply routing strap (two-level) |
| strap_mode_i | input | 2 | Level code, 8/10 MHz mode strap (three-level) |
| spread_o | output | SPREAD_W | Spread depth code, 0 = off, 1..5 increasing |
| xtal_alt_o | output | 1 | 1 = 14.31818 MHz crystal |
| supply_alt_o | output | 1 | 1 = outputs routed to Ethernet-clock supply |
| mode_o | output | 2 | 8/10 MHz output mode |
| pad_oe_o | output | 5 | Per-pad output enables, bit order as strap inputs |

## Verification
The assertions assume that `rst_n` is driven synchronously and is asserted long enough to reach at least one clock edge. They also assume the clock runs throughout reset, so the strap registers hold a defined value at release. The stimulus changes `rst_n` and the strap codes only at falling edges and holds reset for two edges in every trial. It sweeps all 1024 combinations of five 2-bit codes, including the unused code 11. After the capture edge it puts inverted codes on the straps, so any leak of pin activity into the frozen outputs would show.

// File: rtl/clkstrap_pkg.sv
package clkstrap_pkg;
   typedef logic [1:0] lvl_t;
   localparam lvl_t LVL_LOW  = 2'b00;
   localparam lvl_t LVL_HIGH = 2'b01;
   localparam lvl_t LVL_MID  = 2'b10;
   localparam lvl_t LVL_BAD  = 2'b11;

   typedef enum logic [1:0] {
      MODE_OFF = 2'b00,
      MODE_8M  = 2'b01,
      MODE_10M = 2'b10
   } mode_e;

   localparam int unsigned NUM_STRAP  = 5;
   localparam int unsigned IDX_SPR_HI = 0;
   localparam int unsigned IDX_SPR_LO = 1;
   localparam int unsigned IDX_XTAL   = 2;
   localparam int unsigned IDX_SUPPLY = 3;
   localparam int unsigned IDX_MODE   = 4;

   // 1 = three-level strap (default mid), 0 = two-level strap (default low)
   localparam logic [NUM_STRAP-1:0] TRI_MASK = 5'b10010;
endpackage

// File: rtl/strap_sampler.sv
module strap_sampler #(
   parameter int unsigned            N        = 5,
   parameter logic [N-1:0]           TRI_SEL  = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [2*N-1:0] raw_i,
   output logic [2*N-1:0] held_o
);
   import clkstrap_pkg::*;

   for (genvar g = 0; g < N; g++) begin : g_strap
      lvl_t raw_lvl;
      lvl_t norm_lvl;
      lvl_t cap_q;

      assign raw_lvl = raw_i[2*g +: 2];

      if (TRI_SEL[g]) begin : g_tri
         assign norm_lvl = (raw_lvl == LVL_BAD) ? LVL_MID : raw_lvl;
      end else begin : g_two
         assign norm_lvl = (raw_lvl == LVL_HIGH) ? LVL_HIGH : LVL_LOW;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) cap_q <= norm_lvl;
      end

      assign held_o[2*g +: 2] = cap_q;
   end
endmodule

// File: rtl/strap_decoder.sv
module strap_decoder #(
   parameter int unsigned SPREAD_W = 3
) (
   input  clkstrap_pkg::lvl_t          spr_hi_i,
   input  clkstrap_pkg::lvl_t          spr_lo_i,
   input  clkstrap_pkg::lvl_t          xtal_i,
   input  clkstrap_pkg::lvl_t          supply_i,
   input  clkstrap_pkg::lvl_t          mode_i,
   output logic [SPREAD_W-1:0]         spread_o,
   output logic                        xtal_alt_o,
   output logic                        supply_alt_o,
   output clkstrap_pkg::mode_e         mode_o
);
   import clkstrap_pkg::*;

   logic [SPREAD_W-1:0] lo_step;
   logic [SPREAD_W-1:0] hi_base;

   always_comb begin
      unique case (spr_lo_i)
         LVL_LOW:  lo_step = SPREAD_W'(1);
         LVL_HIGH: lo_step = SPREAD_W'(2);
         default:  lo_step = '0;
      endcase
      hi_base  = (spr_hi_i == LVL_HIGH) ? SPREAD_W'(3) : '0;
      spread_o = hi_base + lo_step;
   end

   assign xtal_alt_o   = (xtal_i == LVL_HIGH);
   assign supply_alt_o = (supply_i == LVL_HIGH);

   always_comb begin
      unique case (mode_i)
         LVL_LOW:  mode_o = MODE_OFF;
         LVL_HIGH: mode_o = MODE_10M;
         default:  mode_o = MODE_8M;
      endcase
   end
endmodule

// File: rtl/oe_sequencer.sv
module oe_sequencer #(
   parameter int unsigned N        = 5,
   parameter int unsigned GATE_IDX = 4,
   parameter int unsigned OE_DELAY = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         gate_off_i,
   output logic         lock_o,
   output logic [N-1:0] oe_o
);
   localparam int unsigned CNT_W = $clog2(OE_DELAY + 1);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(OE_DELAY);

   logic             lock_q;
   logic [CNT_W-1:0] cnt_q;
   logic [N-1:0]     oe_mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         lock_q <= 1'b1;
         if (lock_q && cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      oe_mask           = '1;
      oe_mask[GATE_IDX] = ~gate_off_i;
   end

   assign lock_o = lock_q;
   assign oe_o   = (lock_q && cnt_q == CNT_END) ? oe_mask : '0;
endmodule

// File: rtl/clkgen_strap_frontend.sv
module clkgen_strap_frontend #(
   parameter int unsigned SPREAD_W = 3,
   parameter int unsigned OE_DELAY = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          strap_spr_hi_i,
   input  logic [1:0]          strap_spr_lo_i,
   input  logic [1:0]          strap_xtal_i,
   input  logic [1:0]          strap_supply_i,
   input  logic [1:0]          strap_mode_i,
   output logic [SPREAD_W-1:0] spread_o,
   output logic                xtal_alt_o,
   output logic                supply_alt_o,
   output logic [1:0]          mode_o,
   output logic [4:0]          pad_oe_o
);
   import clkstrap_pkg::*;

   localparam int unsigned RAW_W = 2 * NUM_STRAP;

   if (SPREAD_W < 3) begin : g_bad_spread_w
      $error("SPREAD_W must hold codes up to 5");
   end
   if (OE_DELAY < 1) begin : g_bad_oe_delay
      $error("OE_DELAY must be at least 1");
   end

   logic [RAW_W-1:0]    raw_bus;
   logic [RAW_W-1:0]    held_bus;
   logic [SPREAD_W-1:0] dec_spread;
   logic                dec_xtal;
   logic                dec_supply;
   mode_e               dec_mode;
   logic                lock;

   logic [SPREAD_W-1:0] spread_q;
   logic                xtal_q;
   logic                supply_q;
   mode_e               mode_q;

   always_comb begin
      raw_bus = '0;
      raw_bus[2*IDX_SPR_HI +: 2] = strap_spr_hi_i;
      raw_bus[2*IDX_SPR_LO +: 2] = strap_spr_lo_i;
      raw_bus[2*IDX_XTAL   +: 2] = strap_xtal_i;
      raw_bus[2*IDX_SUPPLY +: 2] = strap_supply_i;
      raw_bus[2*IDX_MODE   +: 2] = strap_mode_i;
   end

   strap_sampler #(
      .N       (NUM_STRAP),
      .TRI_SEL (TRI_MASK)
   ) u_sampler (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_bus),
      .held_o (held_bus)
   );

   strap_decoder #(
      .SPREAD_W (SPREAD_W)
   ) u_decoder (
      .spr_hi_i     (held_bus[2*IDX_SPR_HI +: 2]),
      .spr_lo_i     (held_bus[2*IDX_SPR_LO +: 2]),
      .xtal_i       (held_bus[2*IDX_XTAL   +: 2]),
      .supply_i     (held_bus[2*IDX_SUPPLY +: 2]),
      .mode_i       (held_bus[2*IDX_MODE   +: 2]),
      .spread_o     (dec_spread),
      .xtal_alt_o   (dec_xtal),
      .supply_alt_o (dec_supply),
      .mode_o       (dec_mode)
   );

   // Configuration registers load once, on the first edge out of reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         spread_q <= '0;
         xtal_q   <= 1'b0;
         supply_q <= 1'b0;
         mode_q   <= MODE_8M;
      end else if (!lock) begin
         spread_q <= dec_spread;
         xtal_q   <= dec_xtal;
         supply_q <= dec_supply;
         mode_q   <= dec_mode;
      end
   end

   oe_sequencer #(
      .N        (NUM_STRAP),
      .GATE_IDX (IDX_MODE),
      .OE_DELAY (OE_DELAY)
   ) u_oe_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .gate_off_i (mode_q == MODE_OFF),
      .lock_o     (lock),
      .oe_o       (pad_oe_o)
   );

   assign spread_o     = spread_q;
   assign xtal_alt_o   = xtal_q;
   assign supply_alt_o = supply_q;
   assign mode_o       = mode_q;
endmodule

// File: rtl/clkgen_strap_frontend_chk.sv
module clkgen_strap_frontend_chk #(
   parameter int unsigned SPREAD_W = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                lock,
   input logic [SPREAD_W-1:0] spread_o,
   input logic                xtal_alt_o,
   input logic                supply_alt_o,
   input logic [1:0]          mode_o,
   input logic [4:0]          pad_oe_o
);
   a_r1_idle_defaults: assert property (@(posedge clk) disable iff (!rst_n)
      !lock |-> (pad_oe_o == 5'd0 && spread_o == '0 && !xtal_alt_o
                 && !supply_alt_o && mode_o == 2'b01));

   a_r2_spread_range: assert property (@(posedge clk) disable iff (!rst_n)
      spread_o <= SPREAD_W'(5));

   a_r5_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o != 2'b11);

   a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && $past(lock)) |-> ($stable(spread_o) && $stable(xtal_alt_o)
                                 && $stable(supply_alt_o) && $stable(mode_o)));

   a_r9_oe_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe_o != 5'd0) |-> lock);

   a_r9_mode_pad_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe_o != 5'd0) |-> (pad_oe_o[4] == (mode_o != 2'b00)
                               && pad_oe_o[3:0] == 4'hF));

   a_r9_oe_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe_o != 5'd0) |=> $stable(pad_oe_o));
endmodule

bind clkgen_strap_frontend clkgen_strap_frontend_chk #(
   .SPREAD_W (SPREAD_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lock         (lock),
   .spread_o     (spread_o),
   .xtal_alt_o   (xtal_alt_o),
   .supply_alt_o (supply_alt_o),
   .mode_o       (mode_o),
   .pad_oe_o     (pad_oe_o)
);

// File: tb/clkgen_strap_frontend_tb.sv
`timescale 1ns/1ps
module clkgen_strap_frontend_tb;
   localparam int unsigned SPREAD_W = 3;
   localparam int unsigned OE_DELAY = 2;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [1:0]          s_hi = 2'b00, s_lo = 2'b10, s_xt = 2'b00, s_su = 2'b00, s_md = 2'b10;
   logic [SPREAD_W-1:0] spread;
   logic                xtal_alt, supply_alt;
   logic [1:0]          mode;
   logic [4:0]          oe;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   clkgen_strap_frontend #(.SPREAD_W(SPREAD_W), .OE_DELAY(OE_DELAY)) u_dut (
      .clk (clk), .rst_n (rst_n),
      .strap_spr_hi_i (s_hi), .strap_spr_lo_i (s_lo), .strap_xtal_i (s_xt),
      .strap_supply_i (s_su), .strap_mode_i (s_md),
      .spread_o (spread), .xtal_alt_o (xtal_alt), .supply_alt_o (supply_alt),
      .mode_o (mode), .pad_oe_o (oe)
   );

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(logic [9:0] v);
      s_hi = v[1:0]; s_lo = v[3:2]; s_xt = v[5:4]; s_su = v[7:6]; s_md = v[9:8];
   endtask

   function automatic int exp_spread(logic [1:0] hi, logic [1:0] lo);
      int base = (hi == 2'b01) ? 3 : 0;
      int step = (lo == 2'b00) ? 1 : (lo == 2'b01) ? 2 : 0;
      return base + step;
   endfunction

   function automatic int exp_mode(logic [1:0] c);
      return (c == 2'b00) ? 0 : (c == 2'b01) ? 2 : 1;
   endfunction

   task automatic check_cfg(string tag, logic [9:0] v);
      chk({tag, " R2/R6 spread"}, spread, exp_spread(v[1:0], v[3:2]));
      chk({tag, " R3 xtal"}, xtal_alt, (v[5:4] == 2'b01) ? 1 : 0);
      chk({tag, " R4 supply"}, supply_alt, (v[7:6] == 2'b01) ? 1 : 0);
      chk({tag, " R5/R6 mode"}, mode, exp_mode(v[9:8]));
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) begin
         logic [9:0] v = 10'(i);
         int exp_oe = (exp_mode(v[9:8]) == 0) ? 5'b01111 : 5'b11111;
         @(negedge clk);
         rst_n = 1'b0;
         drive(~v);
         @(negedge clk);
         chk("R10 oe cleared on re-reset", oe, 0);
         drive(v);
         @(negedge clk);
         chk("R1 oe in reset", oe, 0);
         chk("R1 spread in reset", spread, 0);
         chk("R1 mode in reset", mode, 1);
         chk("R1 xtal/supply in reset", {xtal_alt, supply_alt}, 0);
         rst_n = 1'b1;
         @(negedge clk);
         check_cfg("R7 capture", v);
         chk("R9 oe low at capture", oe, 0);
         drive(~v);
         for (int k = 1; k < OE_DELAY; k++) begin
            @(negedge clk);
            chk("R9 oe low before delay", oe, 0);
         end
         @(negedge clk);
         chk("R9 oe after delay", oe, exp_oe);
         drive(v ^ 10'h155);
         @(negedge clk);
         check_cfg("R8 frozen", v);
         chk("R8 oe held", oe, exp_oe);
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule